// File: doc/BRIEF.md
# Frame synchronism loss supervisor

This block watches the bit clock and the frame pulse of a PCM highway and decides whether the two agree. It runs on a fast system clock. It samples the bit clock and takes one tick on the selected edge of that clock. On each tick it also samples the frame pulse. It counts ticks between rising edges of the sampled pulse and compares each count with the frame length. The frame length follows from the programmed number of 8-bit slots per frame and from whether the bit clock runs at one or two cycles per bit.

A period that is too short means missing clock ticks or an early pulse. A period that grows past the expected length means extra ticks or a missing pulse. Either one drops the status to out-of-sync at once. The status returns to synchronous only after two back-to-back periods of exactly the right length. Each change of the status sets a sticky interrupt flag, which a one-cycle clear input removes.

Top module: `frame_sync_sup`

## Requirements
- R1: While reset is asserted and directly after it, `in_sync_o` is 0 and `irq_o` is 0.
- R2: A tick is a rising edge of `pdc_i` when `edge_sel_i`=0 and a falling edge when `edge_sel_i`=1. `fsync_i` is sampled only at ticks. A framing edge is a tick whose sample is 1 while the previous tick's sample was 0. A pulse that is high only around the unselected edge is not seen.
- R3: The expected period is `slots_i`×8 ticks, doubled when `double_rate_i`=1. For example, 32 slots at double rate expect 512 ticks. `slots_i` is legal from 4 to 128.
- R4: The first framing edge after reset, or after a dropped reference, only sets a reference. `in_sync_o` becomes 1 on the clock after the tick of the second following edge, when both periods measured exactly the expected length.
- R5: A framing edge that arrives after fewer ticks than expected clears `in_sync_o` on the clock after that tick. That edge becomes the new reference.
- R6: If no framing edge comes on the tick that would complete the expected period, the period counts as wrong. `in_sync_o` goes to 0 and the reference is dropped, so the next edge only re-references.
- R7: `irq_o` is set on the same clock edge at which `in_sync_o` changes. It then stays set until `irq_clr_i`=1 is seen at a clock edge with no change of status. A status change in the same cycle as a clear leaves it set.
- R8: After a loss, synchronism returns only after two new correct periods. One correct period is not enough.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than twice the bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdc_i | input | 1 | PCM bit clock, sampled on clk_i |
| fsync_i | input | 1 | Frame pulse |
| edge_sel_i | input | 1 | 0: rising bit-clock edge is the tick, 1: falling |
| double_rate_i | input | 1 | 1: two clock cycles per bit |
| slots_i | input | SLOT_W | Slots per frame (4..MAX_SLOTS) |
| irq_clr_i | input | 1 | Clear the interrupt flag (write one) |
| in_sync_o | output | 1 | 1 while synchronous |
| irq_o | output | 1 | Sticky flag, set on each status change |

## Verification
The assertions check the following on every cycle:
- The tick counter never passes the expected length while a reference is held.
- The status rises only on a referenced framing edge and falls only on a tick.
- The interrupt flag sets with every status change, never sets without one, and holds until cleared.

The bench scenarios are needed for the rest:
- the exact period count needed to become synchronous, including the two-period recovery after a short frame or a timeout;
- the 512-tick double-rate case;
- the edge-select choice shown with pulses that are visible on only one bit-clock edge;
- the case where set and clear of the interrupt flag coincide.

// File: rtl/fss_pkg.sv
package fss_pkg;
  typedef enum logic {
    TICK_ON_RISE = 1'b0,
    TICK_ON_FALL = 1'b1
  } tick_edge_e;

  localparam int unsigned BITS_PER_SLOT = 8;
endpackage

// File: rtl/fss_sampler.sv
module fss_sampler
  import fss_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdc_i,
  input  logic fsync_i,
  input  logic edge_sel_i,
  output logic tick_o,
  output logic fs_edge_o
);
  logic pdc_q;
  logic fs_q;
  tick_edge_e mode;

  assign mode = tick_edge_e'(edge_sel_i);

  always_comb begin
    unique case (mode)
      TICK_ON_RISE: tick_o = pdc_i & ~pdc_q;
      TICK_ON_FALL: tick_o = ~pdc_i & pdc_q;
      default:      tick_o = 1'b0;
    endcase
  end

  // frame edge judged against the previous tick's sample only
  assign fs_edge_o = tick_o & fsync_i & ~fs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdc_q <= 1'b0;
      fs_q  <= 1'b0;
    end else begin
      pdc_q <= pdc_i;
      if (tick_o) fs_q <= fsync_i;
    end
  end
endmodule

// File: rtl/fss_period.sv
module fss_period #(
  parameter int unsigned CNT_W    = 12,
  parameter int unsigned GOOD_REQ = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             fs_edge_i,
  input  logic [CNT_W-1:0] exp_len_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ref_o,
  output logic             sync_o,
  output logic             chg_o
);
  localparam int unsigned GW = $clog2(GOOD_REQ + 1);
  localparam logic [GW-1:0] GOOD_MAX = GW'(GOOD_REQ);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GW-1:0]    good_q, good_d;
  logic             ref_q, ref_d;
  logic             sync_q, sync_d;
  logic             full;

  assign full = (cnt_q == exp_len_i);

  always_comb begin
    cnt_d  = cnt_q;
    good_d = good_q;
    ref_d  = ref_q;
    if (tick_i) begin
      if (fs_edge_i) begin
        cnt_d = CNT_W'(1);
        ref_d = 1'b1;
        if (ref_q) begin
          if (full) good_d = (good_q == GOOD_MAX) ? GOOD_MAX : good_q + GW'(1);
          else      good_d = '0;
        end
      end else if (ref_q) begin
        if (full) begin
          // period overran: drop reference and wait for a fresh edge
          ref_d  = 1'b0;
          good_d = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
    end
    sync_d = (good_d == GOOD_MAX);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      good_q <= '0;
      ref_q  <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      good_q <= good_d;
      ref_q  <= ref_d;
      sync_q <= sync_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign ref_o  = ref_q;
  assign sync_o = sync_q;
  assign chg_o  = sync_d ^ sync_q;
endmodule

// File: rtl/fss_irq.sv
module fss_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic chg_i,
  input  logic clr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_q <= 1'b0;
    else if (chg_i) irq_q <= 1'b1;
    else if (clr_i) irq_q <= 1'b0;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/frame_sync_sup.sv
module frame_sync_sup
  import fss_pkg::*;
#(
  parameter int unsigned MAX_SLOTS = 128,
  parameter int unsigned SLOT_W    = $clog2(MAX_SLOTS + 1),
  parameter int unsigned CNT_W     = $clog2(MAX_SLOTS * BITS_PER_SLOT * 2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pdc_i,
  input  logic              fsync_i,
  input  logic              edge_sel_i,
  input  logic              double_rate_i,
  input  logic [SLOT_W-1:0] slots_i,
  input  logic              irq_clr_i,
  output logic              in_sync_o,
  output logic              irq_o
);
  localparam int unsigned SLOT_SH = $clog2(BITS_PER_SLOT);

  logic             tick;
  logic             fs_edge;
  logic [CNT_W-1:0] exp_len;
  logic [CNT_W-1:0] cnt;
  logic             has_ref;
  logic             chg;

  assign exp_len = CNT_W'(slots_i) << (SLOT_SH + int'(double_rate_i));

  fss_sampler u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pdc_i      (pdc_i),
    .fsync_i    (fsync_i),
    .edge_sel_i (edge_sel_i),
    .tick_o     (tick),
    .fs_edge_o  (fs_edge)
  );

  fss_period #(.CNT_W(CNT_W), .GOOD_REQ(2)) u_period (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .fs_edge_i (fs_edge),
    .exp_len_i (exp_len),
    .cnt_o     (cnt),
    .ref_o     (has_ref),
    .sync_o    (in_sync_o),
    .chg_o     (chg)
  );

  fss_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chg_i  (chg),
    .clr_i  (irq_clr_i),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick,
  input logic             fs_edge,
  input logic             has_ref,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] exp_len,
  input logic             irq_clr_i,
  input logic             in_sync_o,
  input logic             irq_o
);
  assert_cnt_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    has_ref |-> (cnt <= exp_len));

  assert_rise_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> $past(fs_edge && has_ref));

  assert_fall_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_sync_o) |-> $past(tick));

  assert_irq_on_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_sync_o != $past(in_sync_o)) |-> irq_o);

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (in_sync_o != $past(in_sync_o)));

  assert_irq_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind frame_sync_sup fss_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick      (tick),
  .fs_edge   (fs_edge),
  .has_ref   (has_ref),
  .cnt       (cnt),
  .exp_len   (exp_len),
  .irq_clr_i (irq_clr_i),
  .in_sync_o (in_sync_o),
  .irq_o     (irq_o)
);

// File: tb/frame_sync_sup_tb.sv
`timescale 1ns/1ps
module frame_sync_sup_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdc = 1'b0, fsync = 1'b0, edge_sel = 1'b0, dbl = 1'b0, clr = 1'b0;
  logic [7:0] slots = 8'd4;
  logic       in_sync, irq;
  int         total = 0, bad = 0;
  bit         done = 0;

  always #2.5 clk = ~clk;

  frame_sync_sup u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pdc_i(pdc), .fsync_i(fsync),
    .edge_sel_i(edge_sel), .double_rate_i(dbl), .slots_i(slots),
    .irq_clr_i(clr), .in_sync_o(in_sync), .irq_o(irq)
  );

  // behavioural reference, one step per system clock
  bit m_pdc, m_fs, m_ref, m_sync, m_irq;
  int m_cnt, m_good;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pdc = 0; m_fs = 0; m_ref = 0; m_sync = 0; m_irq = 0; m_cnt = 0; m_good = 0;
    end else begin
      bit tk, ed, ns;
      int want;
      want = slots * 8 * (dbl ? 2 : 1);
      tk = edge_sel ? (m_pdc && !pdc) : (!m_pdc && pdc);
      if (tk) begin
        ed = fsync && !m_fs;
        m_fs = fsync;
        if (ed) begin
          if (m_ref) m_good = (m_cnt == want) ? ((m_good < 2) ? m_good + 1 : 2) : 0;
          m_ref = 1;
          m_cnt = 1;
        end else if (m_ref) begin
          if (m_cnt == want) begin m_ref = 0; m_good = 0; end
          else m_cnt++;
        end
      end
      ns = (m_good == 2);
      if (ns != m_sync) m_irq = 1;
      else if (clr) m_irq = 0;
      m_sync = ns;
      m_pdc = pdc;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (in_sync !== m_sync) begin
        bad++; $display("FAIL R4 model in_sync act=%0b exp=%0b t=%0t", in_sync, m_sync, $time);
      end
      total++;
      if (irq !== m_irq) begin
        bad++; $display("FAIL R7 model irq act=%0b exp=%0b t=%0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  // one bit-clock cycle: fr = pulse level in high phase, ff = in low phase
  task automatic tickc(input logic fr, input logic ff, input logic c);
    @(negedge clk); pdc = 1; fsync = fr; clr = c;
    @(negedge clk); clr = 0;
    @(negedge clk); pdc = 0; fsync = ff;
    @(negedge clk);
  endtask

  // kind 0: no pulse, 1: pulse seen only at rise, 2: only at fall
  task automatic frame(input int n, input int kind, input logic c);
    tickc(kind == 1, kind == 2, c);
    for (int i = 1; i < n; i++) tickc(0, 0, 0);
  endtask

  task automatic clear_irq();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; pdc = 0; fsync = 0; clr = 0;
    repeat (3) @(negedge clk);
    chk("R1 sync in reset", in_sync, 1'b0);
    chk("R1 irq in reset", irq, 1'b0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 sync after reset", in_sync, 1'b0);
    chk("R1 irq after reset", irq, 1'b0);
  endtask

  initial begin
    // single rate, 4 slots, rising edge: 32 ticks
    edge_sel = 0; dbl = 0; slots = 8'd4;
    do_reset();
    frame(32, 1, 0); frame(32, 1, 0);
    chk("R4 one good period only", in_sync, 1'b0);
    frame(32, 1, 0);
    chk("R4 sync after two good periods", in_sync, 1'b1);
    chk("R7 irq on gain", irq, 1'b1);
    clear_irq();
    chk("R7 irq cleared", irq, 1'b0);
    frame(31, 1, 0); frame(32, 1, 0);
    chk("R5 short period loses sync", in_sync, 1'b0);
    chk("R7 irq on loss", irq, 1'b1);
    frame(32, 1, 0);
    chk("R8 one period after loss", in_sync, 1'b0);
    frame(32, 1, 0);
    chk("R8 resync after two periods", in_sync, 1'b1);
    clear_irq();
    frame(33, 1, 0);
    chk("R6 overlong period loses sync", in_sync, 1'b0);
    frame(32, 1, 0); frame(32, 1, 0);
    chk("R6 first edge only re-references", in_sync, 1'b0);
    clear_irq();
    chk("R7 irq cleared before resync", irq, 1'b0);
    frame(32, 1, 1);
    chk("R6 resync after re-reference", in_sync, 1'b1);
    chk("R7 set wins over clear", irq, 1'b1);
    frame(32, 0, 0);
    chk("R6 missing pulse loses sync", in_sync, 1'b0);

    // double rate, 32 slots, falling edge: 512 ticks
    edge_sel = 1; dbl = 1; slots = 8'd32;
    do_reset();
    frame(512, 2, 0); frame(512, 2, 0);
    chk("R3 not yet in sync at 512", in_sync, 1'b0);
    frame(512, 2, 0);
    chk("R3 sync with 512-tick periods", in_sync, 1'b1);
    frame(512, 1, 0);
    chk("R2 rise-only pulse ignored in fall mode", in_sync, 1'b0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule